// File: doc/BRIEF.md
# Serial Register Port with Burst Transfers

This block is the serial slave front end of a small register bank: eight clock and control registers plus a scratch RAM. A host selects the block by pulling chip select low, sends one command byte, and then either writes or reads data bytes on the same four wires. The command picks a single register, a burst over the whole clock and control group, or a burst over the RAM. Every byte travels most significant bit first. Input bits are taken on the rising serial clock edge, and output bits move after the falling edge.

The serial pins pass through two-flop synchronisers into the system clock domain, and their edges are found there. The system clock must run at least four times faster than the serial clock. The serial output is modelled by a data bit and an enable bit that together stand in for a tri-state pad. Each complete data byte that is received becomes a one-cycle write strobe to the storage. The strobe is also brought out at the top so the host side can watch it. The storage is a plain array written so that block RAM can be inferred. Its contents are not cleared by reset.

Top module: `spi_regbank`

## Requirements
- R1: Chip select going low starts a new command byte. Chip select going high ends the transfer at any point, including partway through the command, and the next low period starts again with a fresh command byte.
- R2: While chip select is high, and after reset, the output enable `spi_miso_oe` is 0.
- R3: The block samples `spi_mosi` on rising serial clock edges. `spi_miso` only changes after a falling edge and stays stable while the serial clock is high.
- R4: Command bytes and data bytes are shifted most significant bit first, both in and out.
- R5: Command bit 7 set means read and clear means write, and bits 6..0 give the address. Addresses 0x00-0x07 are the clock and control registers and 0x40-0x5F are the RAM. Address 0x7E selects the clock burst and 0x7F the RAM burst. Any other address reads as 0x00 and ignores writes.
- R6: A single write stores the 8 bits that follow the command at the addressed register. Any further clocks in that transfer change nothing.
- R7: A clock burst write stores the next 8 bytes into registers 0x00..0x07 in order. Any further bytes are ignored.
- R8: A RAM burst write stores each complete byte at consecutive RAM addresses from 0x40. A final byte that is cut short by chip select is not stored.
- R9: On a read, the output enable rises and the first data bit appears after the eighth falling edge, not before. A single read keeps sending the same register for as long as chip select stays low.
- R10: A burst read advances the address after each byte and wraps within its region: after 0x07 for the clock group, and after 0x5F for the RAM.
- R11: Each stored byte produces exactly one `reg_wr_en` pulse, one cycle long, carrying its address and data.
- R12: After reset, `reg_wr_en` is 0 and the block waits for chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Drive enable for the serial output pad |
| reg_wr_en | output | 1 | One-cycle write strobe to the storage |
| reg_wr_addr | output | 7 | Register address of the write |
| reg_wr_data | output | 8 | Byte being written |

## Verification
The hardest situations to reach are the truncated ones: chip select rising partway through a RAM burst byte, or partway through a command. Both leave the block with partly shifted data that must neither be stored nor leak into the next transfer. The bench reaches them with a bit-level transfer task that stops after a chosen number of clocks. Afterwards it reads the neighbouring registers back and counts the write strobes to show nothing was committed. A 33-byte RAM burst read is used to reach the wrap at the end of the RAM region.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_W  = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WDATA,
    ST_RDATA,
    ST_DONE
  } xfer_state_t;

  typedef enum logic [1:0] {
    M_SINGLE,
    M_CBURST,
    M_RBURST
  } xfer_mode_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] q_prev;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
        s3 <= RST_VAL[i];
      end else begin
        s1 <= d_in[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign q[i]      = s2;
    assign q_prev[i] = s3;
  end

  assign rise = q & ~q_prev;
  assign fall = ~q & q_prev;
endmodule

// File: rtl/spi_rb_store.sv
module spi_rb_store #(
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 8,
  parameter int CLK_REGS  = 8,
  parameter int RAM_BASE  = 64,
  parameter int RAM_DEPTH = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = CLK_REGS + RAM_DEPTH;
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W-1:0] CLK_END = ADDR_W'(CLK_REGS);
  localparam logic [ADDR_W-1:0] RAM_LO  = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] RAM_HI  = ADDR_W'(RAM_BASE + RAM_DEPTH);
  localparam logic [ADDR_W-1:0] RAM_OFS = ADDR_W'(RAM_BASE - CLK_REGS);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_q;
  logic              rd_ok;

  function automatic logic mapped(input logic [ADDR_W-1:0] a);
    return (a < CLK_END) || (a >= RAM_LO && a < RAM_HI);
  endfunction

  function automatic logic [IDX_W-1:0] to_idx(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] t;
    t = (a < CLK_END) ? a : a - RAM_OFS;
    return t[IDX_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en && mapped(wr_addr))
      mem[to_idx(wr_addr)] <= wr_data;
  end

  always_ff @(posedge clk) begin
    rd_q  <= mem[to_idx(rd_addr)];
    rd_ok <= mapped(rd_addr);
  end

  assign rd_data = rd_ok ? rd_q : '0;
endmodule

// File: rtl/spi_rb_engine.sv
module spi_rb_engine
  import spi_rb_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int CLK_REGS  = 8,
  parameter int RAM_BASE  = 64,
  parameter int RAM_DEPTH = 32,
  parameter int CBURST_A  = 126,
  parameter int RBURST_A  = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_s,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sdo,
  output logic              sdo_oe
);
  localparam int MAXR  = (RAM_DEPTH > CLK_REGS) ? RAM_DEPTH : CLK_REGS;
  localparam int OFF_W = $clog2(MAXR);
  localparam logic [OFF_W-1:0]  CLK_LAST = OFF_W'(CLK_REGS - 1);
  localparam logic [OFF_W-1:0]  RAM_LAST = OFF_W'(RAM_DEPTH - 1);
  localparam logic [ADDR_W-1:0] RAM_A    = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] RAM_E    = ADDR_W'(RAM_BASE + RAM_DEPTH);

  xfer_state_t       state;
  xfer_mode_t        mode;
  logic [BIT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] shift;
  logic [BYTE_W-1:0] tx;
  logic [ADDR_W-1:0] base;
  logic [OFF_W-1:0]  off;
  logic              load_pend;

  logic [BYTE_W-1:0] byte_in;
  logic [OFF_W-1:0]  off_last;
  logic [OFF_W-1:0]  off_next;
  logic [ADDR_W-1:0] cur_addr;

  always_comb begin
    byte_in  = {shift[BYTE_W-2:0], mosi_s};
    off_last = (mode == M_CBURST) ? CLK_LAST : RAM_LAST;
    off_next = (off == off_last) ? '0 : off + 1'b1;
    cur_addr = base + ADDR_W'(off);
  end

  assign rd_addr = cur_addr;
  assign sdo     = tx[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (rst || cs_n_s) begin
      state     <= ST_IDLE;
      mode      <= M_SINGLE;
      bit_cnt   <= '0;
      shift     <= '0;
      tx        <= '0;
      base      <= '0;
      off       <= '0;
      load_pend <= 1'b0;
      sdo_oe    <= 1'b0;
      wr_en     <= 1'b0;
      if (rst) begin
        wr_addr <= '0;
        wr_data <= '0;
      end
    end else begin
      wr_en <= 1'b0;
      if (state == ST_IDLE) begin
        state   <= ST_CMD;
        bit_cnt <= '0;
      end else if (sclk_rise && state != ST_DONE) begin
        shift   <= byte_in;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BIT_W'(BYTE_W - 1)) begin
          case (state)
            ST_CMD: begin
              off <= '0;
              if (byte_in[ADDR_W-1:0] == ADDR_W'(CBURST_A)) begin
                mode <= M_CBURST;
                base <= '0;
              end else if (byte_in[ADDR_W-1:0] == ADDR_W'(RBURST_A)) begin
                mode <= M_RBURST;
                base <= RAM_A;
              end else begin
                mode <= M_SINGLE;
                base <= byte_in[ADDR_W-1:0];
              end
              if (byte_in[BYTE_W-1]) begin
                state     <= ST_RDATA;
                load_pend <= 1'b1;
              end else begin
                state <= ST_WDATA;
              end
            end
            ST_WDATA: begin
              wr_en   <= 1'b1;
              wr_addr <= cur_addr;
              wr_data <= byte_in;
              case (mode)
                M_SINGLE: state <= ST_DONE;
                M_CBURST: begin
                  if (off == CLK_LAST) state <= ST_DONE;
                  else off <= off_next;
                end
                default:  off <= off_next;
              endcase
            end
            ST_RDATA: load_pend <= 1'b1;
            default: ;
          endcase
        end
      end else if (sclk_fall && state == ST_RDATA) begin
        if (load_pend) begin
          tx        <= rd_data;
          sdo_oe    <= 1'b1;
          load_pend <= 1'b0;
          if (mode != M_SINGLE) off <= off_next;
        end else begin
          tx <= {tx[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  AST_HIZ_DESELECT: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !sdo_oe); // R2
  AST_SDO_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
    (sdo_oe && $past(sdo_oe) && !$past(sclk_fall)) |-> $stable(sdo)); // R3
  AST_WR_AFTER_RISE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(sclk_rise)); // R3
  AST_WR_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R11
  AST_CBURST_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WDATA && mode == M_CBURST) |-> off <= CLK_LAST); // R7
  AST_RAM_WR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == M_RBURST) |-> (wr_addr >= RAM_A && wr_addr < RAM_E)); // R8
  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(sdo_oe) |-> $past(sclk_fall)); // R9
endmodule

// File: rtl/spi_regbank.sv
module spi_regbank #(
  parameter int ADDR_W    = 7,
  parameter int CLK_REGS  = 8,
  parameter int RAM_BASE  = 64,
  parameter int RAM_DEPTH = 32,
  parameter int CBURST_A  = 126,
  parameter int RBURST_A  = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [7:0]        reg_wr_data
);
  import spi_rb_pkg::*;

  localparam int SYNC_W = 3;
  localparam int P_CS   = 2;
  localparam int P_SCLK = 1;
  localparam int P_MOSI = 0;

  logic [SYNC_W-1:0] s_q, s_rise, s_fall;
  logic [ADDR_W-1:0] rd_addr;
  logic [BYTE_W-1:0] rd_data;

  spi_rb_sync #(.W(SYNC_W), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in ({spi_cs_n, spi_sclk, spi_mosi}),
    .q    (s_q),
    .rise (s_rise),
    .fall (s_fall)
  );

  spi_rb_engine #(
    .ADDR_W(ADDR_W), .CLK_REGS(CLK_REGS), .RAM_BASE(RAM_BASE),
    .RAM_DEPTH(RAM_DEPTH), .CBURST_A(CBURST_A), .RBURST_A(RBURST_A)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (s_q[P_CS]),
    .sclk_rise (s_rise[P_SCLK]),
    .sclk_fall (s_fall[P_SCLK]),
    .mosi_s    (s_q[P_MOSI]),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wr_en     (reg_wr_en),
    .wr_addr   (reg_wr_addr),
    .wr_data   (reg_wr_data),
    .sdo       (spi_miso),
    .sdo_oe    (spi_miso_oe)
  );

  spi_rb_store #(
    .ADDR_W(ADDR_W), .DATA_W(BYTE_W), .CLK_REGS(CLK_REGS),
    .RAM_BASE(RAM_BASE), .RAM_DEPTH(RAM_DEPTH)
  ) u_store (
    .clk     (clk),
    .wr_en   (reg_wr_en),
    .wr_addr (reg_wr_addr),
    .wr_data (reg_wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );
endmodule

// File: tb/sim_spi_regbank.sv
module sim_spi_regbank;
  localparam int H = 8;
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{
    16'h005A, 16'h0781, 16'h403C, 16'h5FF0, 16'h1077, 16'h6299
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso, miso_oe, wr_en;
  logic [6:0] wr_addr;
  logic [7:0] wr_data;

  int errors = 0;
  int checks = 0;
  int wr_pulses = 0;
  int long_pulses = 0;
  int r3_viol = 0;
  logic prev_wr = 1'b0;
  logic prev_sclk = 1'b0;
  logic prev_miso = 1'b0;
  logic prev_oe = 1'b0;
  logic done = 1'b0;
  logic [7:0] rbuf [40];

  always #2 clk = ~clk;

  spi_regbank u0 (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .reg_wr_en(wr_en),
    .reg_wr_addr(wr_addr), .reg_wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (wr_en) wr_pulses++;
    if (wr_en && prev_wr) long_pulses++;
    if (!cs_n && sclk && prev_sclk && miso_oe && prev_oe && miso != prev_miso) r3_viol++;
    prev_wr = wr_en; prev_sclk = sclk; prev_miso = miso; prev_oe = miso_oe;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cs_begin();
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      repeat (H) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic cmd_read(input logic [7:0] cmd);
    logic [7:0] junk;
    xbits(cmd, 7, junk);
    mosi = cmd[0];
    repeat (H) @(negedge clk);
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    chk("R9 oe low before 8th fall", miso_oe, 0);
    sclk = 1'b0;
    repeat (H) @(negedge clk);
    chk("R9 oe high after 8th fall", miso_oe, 1);
  endtask

  task automatic wr_single(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] junk;
    cs_begin();
    xbits({1'b0, a}, 8, junk);
    xbits(d, 8, junk);
    cs_end();
  endtask

  task automatic rd_burst(input logic [7:0] cmd, input int n);
    cs_begin();
    cmd_read(cmd);
    for (int k = 0; k < n; k++) xbits(8'h00, 8, rbuf[k]);
    cs_end();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] junk;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 wr_en after reset", wr_en, 0);
    chk("R2 oe after reset", miso_oe, 0);

    // R4 R5 R6: single write then single read of each vector
    for (int v = 0; v < NV; v++) begin
      logic [6:0] a;
      logic [7:0] d, e;
      a = VEC[v][14:8];
      d = VEC[v][7:0];
      e = (a < 7'h08 || (a >= 7'h40 && a < 7'h60)) ? d : 8'h00;
      wr_single(a, d);
      rd_burst({1'b1, a}, 1);
      chk($sformatf("R5 R4 readback addr %0h", a), rbuf[0], e);
    end
    chk("R2 oe low after deselect", miso_oe, 0);

    // R6: extra clocks after a single write are ignored
    wr_single(7'h04, 8'h11);
    wr_pulses = 0;
    cs_begin();
    xbits(8'h03, 8, junk); xbits(8'hA5, 8, junk); xbits(8'h3C, 8, junk);
    cs_end();
    chk("R6 one strobe for single write", wr_pulses, 1);
    rd_burst(8'h84, 1);
    chk("R6 neighbour untouched", rbuf[0], 8'h11);

    // R9: single read repeats same register
    rd_burst(8'h83, 2);
    chk("R9 single read byte0", rbuf[0], 8'hA5);
    chk("R9 single read repeat", rbuf[1], 8'hA5);

    // R7 R11: clock burst write with a surplus byte
    wr_pulses = 0;
    cs_begin();
    xbits(8'h7E, 8, junk);
    for (int k = 0; k < 9; k++) xbits(k < 8 ? 8'h10 + 8'(k) : 8'hEE, 8, junk);
    cs_end();
    chk("R7 R11 clock burst strobes", wr_pulses, 8);
    // R10: clock burst read wraps after register 7
    rd_burst(8'hFE, 10);
    for (int k = 0; k < 10; k++)
      chk($sformatf("R10 R7 clock burst byte %0d", k), rbuf[k], 8'h10 + 8'(k % 8));

    // R8: RAM burst with a truncated final byte
    wr_single(7'h43, 8'hC3);
    wr_pulses = 0;
    cs_begin();
    xbits(8'h7F, 8, junk);
    xbits(8'h21, 8, junk); xbits(8'h22, 8, junk); xbits(8'h23, 8, junk);
    xbits(8'hFF, 4, junk);
    cs_end();
    chk("R8 R11 RAM burst strobes", wr_pulses, 3);
    rd_burst(8'hC3, 1);
    chk("R8 partial byte dropped", rbuf[0], 8'hC3);
    rd_burst(8'hC1, 1);
    chk("R8 second RAM byte", rbuf[0], 8'h22);

    // R10: RAM burst read wraps after 0x5F
    rd_burst(8'hFF, 33);
    chk("R10 RAM burst first", rbuf[0], 8'h21);
    chk("R10 RAM burst last", rbuf[31], 8'hF0);
    chk("R10 RAM burst wrap", rbuf[32], 8'h21);

    // R1: abort mid-command, then mid-data of a write
    cs_begin(); xbits(8'h06, 4, junk); cs_end();
    wr_single(7'h05, 8'h6B);
    rd_burst(8'h85, 1);
    chk("R1 fresh command after abort", rbuf[0], 8'h6B);
    wr_single(7'h06, 8'h22);
    wr_pulses = 0;
    cs_begin(); xbits(8'h06, 8, junk); xbits(8'h99, 5, junk); cs_end();
    chk("R1 aborted write no strobe", wr_pulses, 0);
    rd_burst(8'h86, 1);
    chk("R1 aborted write kept old", rbuf[0], 8'h22);

    chk("R11 no strobe longer than one cycle", long_pulses, 0);
    chk("R3 output steady while SCLK high", r3_viol, 0);
    chk("R2 oe low at end", miso_oe, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule